// File: doc/BRIEF.md
# SMBus Host Controller Register Frontend

This block is the software-facing register file of an SMBus host controller, paired with a small transaction sequencer. Software writes a target address, a command byte, two data bytes and a control byte through a byte-wide register port. When the control write carries the start bit, the block latches the protocol code and raises a request toward a downstream bus engine. The request carries the protocol, the direction, the 7-bit target, the command and both data bytes. The request stays up until the engine acknowledges it.

When the engine acknowledges a read, the returned bytes are stored in the data registers. Block transfers move their payload through a buffer of 32 bytes. Software reaches the buffer through a single data port whose index advances on every access and wraps to zero. The engine reaches it through a byte-step strobe that uses the same index. Starting a transaction resets the index, so both sides walk the buffer from entry 0.

Top module: `smbus_host_regs`

## Requirements
- R1: After reset, every register reads 0 and `req_valid` is low. The offsets are: 0 status, 2 control, 3 command, 4 address, 5 data 0, 6 data 1 and 7 block data port. Offset 1 always reads 0.
- R2: A control read returns the last written control bits 4:0 in bits 4:0. Bits 7:5 read as 0, so the start bit (bit 6) never reads back.
- R3: A control write made while idle, with bit 6 set and bits 4:2 holding a legal code (0 quick, 1 byte, 2 byte-data, 3 word, 5 block), raises `req_valid` and status bit 0 from the next cycle. `req_proto` then equals the code, `req_read` equals address bit 0, `req_target` equals address bits 7:1, and `req_cmd`, `req_wd0` and `req_wd1` carry command, data 0 and data 1.
- R4: `req_valid` stays high until `req_ack` is sampled high. From the following cycle `req_valid` and status bit 0 are low and status bit 1 (done) is set.
- R5: When a read (address bit 0 = 1) completes, byte and byte-data load data 0 from `rsp_byte0`, word loads data 0 from `rsp_byte0` and data 1 from `rsp_byte1`, and block loads the byte count from `rsp_byte0` into data 0. Quick commands and all writes leave both data registers unchanged.
- R6: A start with code 4, 6 or 7 issues no request and sets status bit 2 (failed).
- R7: Writing 1 to status bit 1 or bit 2 clears that bit, and writing 0 leaves it unchanged. Status bit 0 cannot be written.
- R8: Each read or write of the block port, made while idle, accesses the buffer entry at the current index and then increments the index. The index wraps from 31 to 0.
- R9: A start resets the buffer index to 0.
- R10: During a block transaction, `blk_wdata` shows the buffer entry at the index. Each `blk_step` advances the index with wrap. On a block read, each step also stores `blk_rdata` into the entry first.
- R11: A control write made while a transaction is in flight has no effect. The control readback and `req_proto` are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 3 | Register offset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (advances the block index at offset 7) |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational from the offset |
| req_valid | output | 1 | Transaction request to the bus engine |
| req_proto | output | 3 | Latched protocol code |
| req_read | output | 1 | Direction, 1 = read |
| req_target | output | 7 | Target address |
| req_cmd | output | 8 | Command byte |
| req_wd0 | output | 8 | Data 0 (write byte, low word byte or block count) |
| req_wd1 | output | 8 | Data 1 (high word byte) |
| req_ack | input | 1 | Engine completion acknowledge |
| rsp_byte0 | input | 8 | Returned byte 0 or block count |
| rsp_byte1 | input | 8 | Returned high word byte |
| blk_step | input | 1 | Engine moves one block byte |
| blk_rdata | input | 8 | Block byte returned by the engine |
| blk_wdata | output | 8 | Block byte at the current index |

## Verification
The bench fills the buffer with 33 bytes so that the last byte lands in entry 0. A missing wrap would instead push that byte into a nonexistent entry 32, and the block write would then show the wrong first byte. The bench reads the block port across the 31-to-0 boundary after a block read, which exposes an index that does not reset on start or that drops engine-stored bytes. It checks that a write completion leaves the data registers alone and that a word read fills both of them. A design that treated every acknowledge as a read would corrupt the write cases in the table. An illegal code, a start issued mid-flight and status writes of zero bits are also driven, which catch a request raised for a bad code, a second start that overwrites the latched protocol, and clearing logic that ignores which bits were written.

// File: rtl/smbh_pkg.sv
package smbh_pkg;

    localparam int DW = 8;

    typedef enum logic [2:0] {
        PR_QUICK = 3'd0,
        PR_BYTE  = 3'd1,
        PR_BDATA = 3'd2,
        PR_WORD  = 3'd3,
        PR_BLOCK = 3'd5
    } proto_e;

    localparam logic [2:0] OFS_STAT = 3'd0;
    localparam logic [2:0] OFS_CTL  = 3'd2;
    localparam logic [2:0] OFS_CMD  = 3'd3;
    localparam logic [2:0] OFS_ADDR = 3'd4;
    localparam logic [2:0] OFS_D0   = 3'd5;
    localparam logic [2:0] OFS_D1   = 3'd6;
    localparam logic [2:0] OFS_BLK  = 3'd7;

    localparam int START_BIT = 6;

    typedef struct packed {
        logic [4:0]    ctl;
        logic [DW-1:0] cmd;
        logic [DW-1:0] addr;
        logic [DW-1:0] d0;
        logic [DW-1:0] d1;
        logic [2:0]    proto;
        logic          busy;
        logic          done;
        logic          fail;
    } hc_regs_t;

    function automatic logic proto_legal(input logic [2:0] code);
        return (code == PR_QUICK) || (code == PR_BYTE) || (code == PR_BDATA) ||
               (code == PR_WORD)  || (code == PR_BLOCK);
    endfunction

endpackage

// File: rtl/smbh_proto_dec.sv
module smbh_proto_dec
    import smbh_pkg::*;
(
    input  logic [2:0] code,
    output logic       is_block,
    output logic       ld_d0,
    output logic       ld_d1
);
    // Which data registers a completed read refreshes, per protocol.
    always_comb begin
        is_block = 1'b0;
        ld_d0    = 1'b0;
        ld_d1    = 1'b0;
        unique case (code)
            PR_BYTE, PR_BDATA: ld_d0 = 1'b1;
            PR_WORD: begin
                ld_d0 = 1'b1;
                ld_d1 = 1'b1;
            end
            PR_BLOCK: begin
                is_block = 1'b1;
                ld_d0    = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/smbh_blkbuf.sv
module smbh_blkbuf #(
    parameter int DEPTH = 32,
    parameter int W     = 8,
    localparam int IW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [IW-1:0] idx,
    input  logic [W-1:0]  wdata,
    output logic [W-1:0]  rdata
);
    logic [W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem_q[idx] <= wdata;
    end

    assign rdata = mem_q[idx];
endmodule

// File: rtl/smbus_host_regs.sv
module smbus_host_regs
    import smbh_pkg::*;
#(
    parameter int BUF_DEPTH = 32
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] reg_addr,
    input  logic       reg_wr,
    input  logic       reg_rd,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    output logic       req_valid,
    output logic [2:0] req_proto,
    output logic       req_read,
    output logic [6:0] req_target,
    output logic [7:0] req_cmd,
    output logic [7:0] req_wd0,
    output logic [7:0] req_wd1,
    input  logic       req_ack,
    input  logic [7:0] rsp_byte0,
    input  logic [7:0] rsp_byte1,
    input  logic       blk_step,
    input  logic [7:0] blk_rdata,
    output logic [7:0] blk_wdata
);
    localparam int IW = $clog2(BUF_DEPTH);
    localparam logic [IW-1:0] IDX_LAST = IW'(BUF_DEPTH - 1);

    hc_regs_t      q, n;
    logic [IW-1:0] idx_q, idx_d, idx_inc;
    logic          run_block, run_ld0, run_ld1;
    logic          port_blk, eng_step, buf_we;
    logic [7:0]    buf_wdata, buf_rdata;

    smbh_proto_dec u_dec (
        .code     (q.proto),
        .is_block (run_block),
        .ld_d0    (run_ld0),
        .ld_d1    (run_ld1)
    );

    assign idx_inc  = (idx_q == IDX_LAST) ? '0 : idx_q + 1'b1;
    assign port_blk = !q.busy && (reg_wr || reg_rd) && (reg_addr == OFS_BLK);
    assign eng_step = q.busy && run_block && blk_step;
    assign buf_we   = (eng_step && q.addr[0]) ||
                      (!q.busy && reg_wr && (reg_addr == OFS_BLK));
    assign buf_wdata = q.busy ? blk_rdata : reg_wdata;

    smbh_blkbuf #(.DEPTH(BUF_DEPTH), .W(DW)) u_buf (
        .clk   (clk),
        .we    (buf_we),
        .idx   (idx_q),
        .wdata (buf_wdata),
        .rdata (buf_rdata)
    );

    always_comb begin
        n     = q;
        idx_d = idx_q;
        if (reg_wr) begin
            unique case (reg_addr)
                OFS_STAT: begin
                    if (reg_wdata[1]) n.done = 1'b0;
                    if (reg_wdata[2]) n.fail = 1'b0;
                end
                OFS_CTL: if (!q.busy) begin
                    n.ctl = reg_wdata[4:0];
                    if (reg_wdata[START_BIT]) begin
                        idx_d = '0;
                        if (proto_legal(reg_wdata[4:2])) begin
                            n.busy  = 1'b1;
                            n.proto = reg_wdata[4:2];
                        end else begin
                            n.fail = 1'b1;
                        end
                    end
                end
                OFS_CMD:  n.cmd  = reg_wdata;
                OFS_ADDR: n.addr = reg_wdata;
                OFS_D0:   n.d0   = reg_wdata;
                OFS_D1:   n.d1   = reg_wdata;
                default: ;
            endcase
        end
        if (port_blk || eng_step) idx_d = idx_inc;
        if (q.busy && req_ack) begin
            n.busy = 1'b0;
            n.done = 1'b1;
            if (q.addr[0]) begin
                if (run_ld0) n.d0 = rsp_byte0;
                if (run_ld1) n.d1 = rsp_byte1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q     <= '0;
            idx_q <= '0;
        end else begin
            q     <= n;
            idx_q <= idx_d;
        end
    end

    always_comb begin
        unique case (reg_addr)
            OFS_STAT: reg_rdata = {5'b0, q.fail, q.done, q.busy};
            OFS_CTL:  reg_rdata = {3'b0, q.ctl};
            OFS_CMD:  reg_rdata = q.cmd;
            OFS_ADDR: reg_rdata = q.addr;
            OFS_D0:   reg_rdata = q.d0;
            OFS_D1:   reg_rdata = q.d1;
            OFS_BLK:  reg_rdata = buf_rdata;
            default:  reg_rdata = '0;
        endcase
    end

    assign req_valid  = q.busy;
    assign req_proto  = q.proto;
    assign req_read   = q.addr[0];
    assign req_target = q.addr[7:1];
    assign req_cmd    = q.cmd;
    assign req_wd0    = q.d0;
    assign req_wd1    = q.d1;
    assign blk_wdata  = buf_rdata;

    // R3
    start_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == OFS_CTL && reg_wdata[START_BIT] && !req_valid &&
         proto_legal(reg_wdata[4:2]))
        |=> (req_valid && req_proto == $past(reg_wdata[4:2])));

    // R4
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ack) |=> req_valid);

    // R4
    ack_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ack) |=> (!req_valid && q.done));

    // R6
    bad_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == OFS_CTL && reg_wdata[START_BIT] && !req_valid &&
         !proto_legal(reg_wdata[4:2]))
        |=> (!req_valid && q.fail));

    // R2
    ctl_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == OFS_CTL) |-> (reg_rdata[7:5] == 3'b0));

    // R8
    idx_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (idx_q == IDX_LAST && (port_blk || eng_step) && !(reg_wr && reg_addr == OFS_CTL))
        |=> (idx_q == '0));

    // R11
    busy_ctl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ack) |=> $stable(req_proto));
endmodule

// File: tb/smbus_host_regs_tb.sv
module smbus_host_regs_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] reg_addr = '0;
    logic       reg_wr = 1'b0, reg_rd = 1'b0;
    logic [7:0] reg_wdata = '0, reg_rdata;
    logic       req_valid, req_read;
    logic [2:0] req_proto;
    logic [6:0] req_target;
    logic [7:0] req_cmd, req_wd0, req_wd1;
    logic       req_ack = 1'b0;
    logic [7:0] rsp_byte0 = '0, rsp_byte1 = '0;
    logic       blk_step = 1'b0;
    logic [7:0] blk_rdata = '0, blk_wdata;

    int n_chk = 0, n_err = 0;
    bit fin = 1'b0;

    always #2 clk = ~clk;

    smbus_host_regs u_dut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .req_valid(req_valid),
        .req_proto(req_proto), .req_read(req_read), .req_target(req_target),
        .req_cmd(req_cmd), .req_wd0(req_wd0), .req_wd1(req_wd1), .req_ack(req_ack),
        .rsp_byte0(rsp_byte0), .rsp_byte1(rsp_byte1), .blk_step(blk_step),
        .blk_rdata(blk_rdata), .blk_wdata(blk_wdata)
    );

    typedef struct packed {
        logic [2:0] pr;
        logic [7:0] ad, cm, d0, d1, r0, r1, e0, e1;
    } vec_t;

    localparam vec_t VEC [6] = '{
        '{3'd0, 8'hA0, 8'h11, 8'h22, 8'h33, 8'h99, 8'h98, 8'h22, 8'h33},
        '{3'd1, 8'h51, 8'h44, 8'h00, 8'h55, 8'h7E, 8'h7F, 8'h7E, 8'h55},
        '{3'd2, 8'h3C, 8'h10, 8'hAB, 8'h00, 8'h12, 8'h34, 8'hAB, 8'h00},
        '{3'd2, 8'h3D, 8'h20, 8'h00, 8'h66, 8'hC3, 8'h5A, 8'hC3, 8'h66},
        '{3'd3, 8'h91, 8'h30, 8'h00, 8'h00, 8'h34, 8'h12, 8'h34, 8'h12},
        '{3'd3, 8'h90, 8'h31, 8'hEF, 8'hBE, 8'h01, 8'h02, 8'hEF, 8'hBE}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // every task starts and ends at a falling edge and spans one cycle
    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        reg_addr = a; reg_rd = 1'b1;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic ack(input logic [7:0] b0, input logic [7:0] b1);
        req_ack = 1'b1; rsp_byte0 = b0; rsp_byte1 = b1;
        @(negedge clk);
        req_ack = 1'b0;
    endtask

    task automatic step(input logic [7:0] bin);
        blk_step = 1'b1; blk_rdata = bin;
        @(negedge clk);
        blk_step = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!fin) begin
            n_chk++; n_err++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 req_valid", req_valid, 0);
        for (int a = 0; a < 7; a++) begin
            rd(3'(a), v);
            chk("R1 reset reg", v, 0);
        end

        // table of protocol cases (R3, R4, R5)
        for (int i = 0; i < 6; i++) begin
            wr(3'd3, VEC[i].cm);
            wr(3'd4, VEC[i].ad);
            wr(3'd5, VEC[i].d0);
            wr(3'd6, VEC[i].d1);
            wr(3'd2, 8'h40 | {3'b0, VEC[i].pr, 2'b0});
            chk("R3 req_valid", req_valid, 1);
            chk("R3 proto", req_proto, VEC[i].pr);
            chk("R3 dir", req_read, VEC[i].ad[0]);
            chk("R3 target", req_target, VEC[i].ad[7:1]);
            chk("R3 cmd", req_cmd, VEC[i].cm);
            chk("R3 wd", {req_wd1, req_wd0}, {VEC[i].d1, VEC[i].d0});
            @(negedge clk);
            chk("R4 hold", req_valid, 1);
            rd(3'd0, v);
            chk("R3 busy status", v, 8'h01);
            ack(VEC[i].r0, VEC[i].r1);
            chk("R4 released", req_valid, 0);
            rd(3'd0, v);
            chk("R4 done status", v, 8'h02);
            rd(3'd5, v);
            chk("R5 data0", v, VEC[i].e0);
            rd(3'd6, v);
            chk("R5 data1", v, VEC[i].e1);
            wr(3'd0, 8'h02);
        end

        // R8: 33 port writes, the last wraps onto entry 0
        for (int i = 0; i < 33; i++) wr(3'd7, 8'h80 + 8'(i));
        rd(3'd7, v);
        chk("R8 wrapped write", v, 8'h81);

        // R9, R10 block write
        wr(3'd4, 8'h40);
        wr(3'd5, 8'h03);
        wr(3'd2, 8'h54);
        chk("R9 index reset", blk_wdata, 8'hA0);
        step(8'h00);
        chk("R10 step 1", blk_wdata, 8'h81);
        step(8'h00);
        chk("R10 step 2", blk_wdata, 8'h82);
        ack(8'hFF, 8'hFF);
        rd(3'd5, v);
        chk("R5 block write keeps data0", v, 8'h03);
        rd(3'd2, v);
        chk("R2 control readback", v, 8'h14);

        // block read with mid-flight control write (R11)
        wr(3'd4, 8'h41);
        wr(3'd2, 8'h54);
        step(8'h5A);
        step(8'h5B);
        wr(3'd2, 8'h44);
        chk("R11 proto kept", req_proto, 3'd5);
        rd(3'd2, v);
        chk("R11 control kept", v, 8'h14);
        step(8'h5C);
        ack(8'h03, 8'h00);
        rd(3'd5, v);
        chk("R5 block count", v, 8'h03);
        for (int i = 3; i < 32; i++) rd(3'd7, v);
        chk("R8 last entry", v, 8'h9F);
        rd(3'd7, v);
        chk("R10 stored 0", v, 8'h5A);
        rd(3'd7, v);
        chk("R10 stored 1", v, 8'h5B);
        rd(3'd7, v);
        chk("R10 stored 2", v, 8'h5C);

        // R6 illegal code, R7 clearing
        wr(3'd0, 8'h02);
        wr(3'd2, 8'h50);
        chk("R6 no request", req_valid, 0);
        rd(3'd0, v);
        chk("R6 failed", v, 8'h04);
        wr(3'd0, 8'h02);
        rd(3'd0, v);
        chk("R7 zero bit kept", v, 8'h04);
        wr(3'd0, 8'h04);
        rd(3'd0, v);
        chk("R7 cleared", v, 8'h00);
        wr(3'd4, 8'h20);
        wr(3'd2, 8'h40);
        wr(3'd0, 8'h07);
        rd(3'd0, v);
        chk("R7 busy not writable", v, 8'h01);
        ack(8'h00, 8'h00);
        rd(3'd1, v);
        chk("R1 offset 1", v, 8'h00);

        fin = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
        $finish;
    end
endmodule